// File: doc/BRIEF.md
# Grouped-Priority Physical Channel Allocator

This block decides which physical DMA channel a virtual client gets. Each physical channel has a fixed priority level. The level is taken from bits [3:2] of the channel index, so the second bank of sixteen channels repeats the level pattern of the first bank. A client with queued work raises its request bit. The allocator grants the most urgent free channel and records the client as that channel's owner. The channel stays bound to that client until the client hands it back through the release port. A client typically does this when it finds its own queue empty after a completion, which lets its next request win a more urgent channel.

Only one request is served per cycle. If several clients ask together, the lowest client ID wins and the others simply try again. A request that finds every channel taken is refused at once and nothing waits inside the block. The per-channel busy bits and owner fields are exported continuously for the engine that runs the descriptors.

Top module: `prio_chan_alloc`

## Requirements
- R1: After reset every channel reads free with owner 0, and the grant, refusal and release-error outputs are all low.
- R2: The level of channel i is (i>>2)&3, and 0 is the most urgent level. The search covers (((NUM_CH-1)&15)>>2)+1 levels, from level 0 upward. Within a level it takes the lowest free index, so channel 16 is granted only while channels 0 to 3 are all busy.
- R3: A served request produces a single-cycle grantValid in the cycle after the request. That pulse carries the channel index and the client ID. In the same cycle the channel's busy bit is set and its owner field holds the client ID, packed as field i at bits [i*3 +: 3].
- R4: A busy channel is never granted again until it has been released. No channel ever holds two owners.
- R5: When several request bits are high in one cycle, only the lowest client ID is served. The others get no response in that cycle.
- R6: A served request that finds no free channel produces a single-cycle denyValid carrying the client ID. Busy and owner state do not change.
- R7: Releasing a busy channel clears its busy bit and owner in the cycle after the release. A later request can then win that channel again.
- R8: Releasing a channel that is not busy, or an index at or above NUM_CH, changes no state and raises relErr for exactly one cycle.
- R9: A request and a release in the same cycle are judged against the state before the release. The channel being released cannot be granted in that cycle.
- R10: grantValid and denyValid are never high together. When neither is high, grantChan and grantClient read 0. When only denyValid is high, grantChan reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | NUM_CLIENTS | One request bit per client |
| relValid | input | 1 | Release strobe |
| relChan | input | 5 | Index of the channel being released |
| grantValid | output | 1 | Grant pulse |
| denyValid | output | 1 | Refusal pulse (no free channel) |
| grantChan | output | 5 | Granted channel index |
| grantClient | output | 3 | Client that was served or refused |
| relErr | output | 1 | Pulse on a release of a channel that is not busy |
| chanBusy | output | NUM_CH | Busy bit per channel |
| chanOwner | output | NUM_CH*3 | Owner client ID per channel |

## Verification
The properties assume that a release names a channel index, and they tolerate indices that are out of range or not busy. The properties also assume that request bits may arrive in any combination, including every client at once and in back-to-back cycles. Random stimulus stays legal simply by drawing request vectors and release indices across the full range. Releases are biased toward busy channels so that the pool keeps filling and draining, and the refusal path and the search past the first bank are both reached. Directed sequences drive the exact fill order, a full pool, a release in the same cycle as a request, and a double release.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  parameter int ChIdxW   = 5;
  parameter int ClientIdW = 3;

  typedef struct packed {
    logic                 grantEn;
    logic                 denyEn;
    logic [ChIdxW-1:0]    chanIdx;
    logic [ClientIdW-1:0] clientId;
    logic                 relEn;
    logic                 relBad;
    logic [ChIdxW-1:0]    relIdx;
  } allocStrobes_t;
endpackage

// File: rtl/alloc_ctrl.sv
module alloc_ctrl
  import alloc_pkg::*;
#(
  parameter int NUM_CH      = 32,
  parameter int NUM_CLIENTS = 8
) (
  input  logic [NUM_CLIENTS-1:0] reqVec,
  input  logic                   relValid,
  input  logic [ChIdxW-1:0]      relChan,
  input  logic [NUM_CH-1:0]      chanBusy,
  output allocStrobes_t          strobes
);
  localparam int NUM_LEVELS = (((NUM_CH - 1) & 15) >> 2) + 1;

  logic                 reqHit;
  logic [ClientIdW-1:0] reqId;
  logic [NUM_LEVELS-1:0] lvlAnyV;
  logic [ChIdxW-1:0]    lvlIdx [NUM_LEVELS];
  logic                 found;
  logic [ChIdxW-1:0]    pick;
  logic                 relInRange;
  logic                 relOk;

  // lowest client ID wins
  always_comb begin
    reqHit = 1'b0;
    reqId  = '0;
    for (int c = NUM_CLIENTS - 1; c >= 0; c--) begin
      if (reqVec[c]) begin
        reqHit = 1'b1;
        reqId  = ClientIdW'(c);
      end
    end
  end

  // one first-free encoder per priority level
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : genLvl
    logic                anyHere;
    logic [ChIdxW-1:0]   idxHere;
    always_comb begin
      anyHere = 1'b0;
      idxHere = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
        if ((((i >> 2) & 3) == l) && !chanBusy[i]) begin
          anyHere = 1'b1;
          idxHere = ChIdxW'(i);
        end
      end
    end
    assign lvlAnyV[l] = anyHere;
    assign lvlIdx[l]  = idxHere;
  end

  // most urgent level with a free channel
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int l = NUM_LEVELS - 1; l >= 0; l--) begin
      if (lvlAnyV[l]) begin
        found = 1'b1;
        pick  = lvlIdx[l];
      end
    end
  end

  assign relInRange = (32'(relChan) < NUM_CH);
  assign relOk      = relValid && relInRange && chanBusy[relChan];

  always_comb begin
    strobes          = '0;
    strobes.grantEn  = reqHit && found;
    strobes.denyEn   = reqHit && !found;
    strobes.chanIdx  = (reqHit && found) ? pick : '0;
    strobes.clientId = reqHit ? reqId : '0;
    strobes.relEn    = relOk;
    strobes.relBad   = relValid && !relOk;
    strobes.relIdx   = relChan;
  end
endmodule

// File: rtl/alloc_dp.sv
module alloc_dp
  import alloc_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  allocStrobes_t               strobes,
  output logic                        grantValid,
  output logic                        denyValid,
  output logic [ChIdxW-1:0]           grantChan,
  output logic [ClientIdW-1:0]        grantClient,
  output logic                        relErr,
  output logic [NUM_CH-1:0]           chanBusy,
  output logic [NUM_CH*ClientIdW-1:0] chanOwner
);
  logic                 busyQ  [NUM_CH];
  logic [ClientIdW-1:0] ownerQ [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : genCh
    localparam logic [ChIdxW-1:0] MY_IDX = ChIdxW'(ch);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busyQ[ch]  <= 1'b0;
        ownerQ[ch] <= '0;
      end else if (strobes.grantEn && strobes.chanIdx == MY_IDX) begin
        busyQ[ch]  <= 1'b1;
        ownerQ[ch] <= strobes.clientId;
      end else if (strobes.relEn && strobes.relIdx == MY_IDX) begin
        busyQ[ch]  <= 1'b0;
        ownerQ[ch] <= '0;
      end
    end
    assign chanBusy[ch] = busyQ[ch];
    assign chanOwner[ch*ClientIdW +: ClientIdW] = ownerQ[ch];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid  <= 1'b0;
      denyValid   <= 1'b0;
      grantChan   <= '0;
      grantClient <= '0;
      relErr      <= 1'b0;
    end else begin
      grantValid  <= strobes.grantEn;
      denyValid   <= strobes.denyEn;
      grantChan   <= strobes.chanIdx;
      grantClient <= strobes.clientId;
      relErr      <= strobes.relBad;
    end
  end
endmodule

// File: rtl/prio_chan_alloc.sv
module prio_chan_alloc
  import alloc_pkg::*;
#(
  parameter int NUM_CH      = 32,
  parameter int NUM_CLIENTS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CLIENTS-1:0]      reqVec,
  input  logic                        relValid,
  input  logic [ChIdxW-1:0]           relChan,
  output logic                        grantValid,
  output logic                        denyValid,
  output logic [ChIdxW-1:0]           grantChan,
  output logic [ClientIdW-1:0]        grantClient,
  output logic                        relErr,
  output logic [NUM_CH-1:0]           chanBusy,
  output logic [NUM_CH*ClientIdW-1:0] chanOwner
);
  allocStrobes_t strobes;

  alloc_ctrl #(.NUM_CH(NUM_CH), .NUM_CLIENTS(NUM_CLIENTS)) uCtrl (
    .reqVec   (reqVec),
    .relValid (relValid),
    .relChan  (relChan),
    .chanBusy (chanBusy),
    .strobes  (strobes)
  );

  alloc_dp #(.NUM_CH(NUM_CH)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .grantValid  (grantValid),
    .denyValid   (denyValid),
    .grantChan   (grantChan),
    .grantClient (grantClient),
    .relErr      (relErr),
    .chanBusy    (chanBusy),
    .chanOwner   (chanOwner)
  );
endmodule

// File: rtl/alloc_checker.sv
module alloc_checker
  import alloc_pkg::*;
#(
  parameter int NUM_CH      = 32,
  parameter int NUM_CLIENTS = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_CLIENTS-1:0] reqVec,
  input logic                   relValid,
  input logic [ChIdxW-1:0]      relChan,
  input logic                   grantValid,
  input logic                   denyValid,
  input logic [ChIdxW-1:0]      grantChan,
  input logic                   relErr,
  input logic [NUM_CH-1:0]      chanBusy
);
  logic [NUM_CH-1:0] prevBusy;
  logic              prevReqAny;
  logic              prevRelValid;
  logic [ChIdxW-1:0] prevRelChan;
  logic              betterFree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBusy     <= '0;
      prevReqAny   <= 1'b0;
      prevRelValid <= 1'b0;
      prevRelChan  <= '0;
    end else begin
      prevBusy     <= chanBusy;
      prevReqAny   <= |reqVec;
      prevRelValid <= relValid;
      prevRelChan  <= relChan;
    end
  end

  always_comb begin
    betterFree = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!prevBusy[i] &&
          ((((i >> 2) & 3) < ((int'(grantChan) >> 2) & 3)) ||
           ((((i >> 2) & 3) == ((int'(grantChan) >> 2) & 3)) && i < int'(grantChan))))
        betterFree = 1'b1;
    end
  end

  a_r4_grant_was_free: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (!prevBusy[grantChan] && chanBusy[grantChan]));

  a_r2_most_urgent: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> !betterFree);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(grantValid && denyValid));

  a_r3_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid || denyValid) |-> prevReqAny);

  a_r6_deny_only_full: assert property (@(posedge clk) disable iff (!rstN)
    denyValid |-> (&prevBusy));

  a_r7_release_frees: assert property (@(posedge clk) disable iff (!rstN)
    (prevRelValid && (32'(prevRelChan) < NUM_CH) && prevBusy[prevRelChan]) |-> !chanBusy[prevRelChan]);

  a_r8_bad_release_inert: assert property (@(posedge clk) disable iff (!rstN)
    (relErr && !grantValid) |-> (prevRelValid && chanBusy == prevBusy));
endmodule

bind prio_chan_alloc alloc_checker #(.NUM_CH(NUM_CH), .NUM_CLIENTS(NUM_CLIENTS)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqVec     (reqVec),
  .relValid   (relValid),
  .relChan    (relChan),
  .grantValid (grantValid),
  .denyValid  (denyValid),
  .grantChan  (grantChan),
  .relErr     (relErr),
  .chanBusy   (chanBusy)
);

// File: tb/sim_prio_chan_alloc.sv
`timescale 1ns/1ps
module sim_prio_chan_alloc;
  localparam int NCH = 32;
  localparam int NCL = 8;
  localparam int CW  = 3;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCL-1:0] reqVec = '0;
  logic           relValid = 1'b0;
  logic [4:0]     relChan = '0;
  logic           grantValid, denyValid, relErr;
  logic [4:0]     grantChan;
  logic [2:0]     grantClient;
  logic [NCH-1:0] chanBusy;
  logic [NCH*CW-1:0] chanOwner;

  int vecCount = 0;
  int failCount = 0;
  bit done = 0;
  bit refBusy [NCH];
  int refOwner [NCH];

  always #2 clk = ~clk;

  prio_chan_alloc #(.NUM_CH(NCH), .NUM_CLIENTS(NCL)) u0 (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .relValid(relValid), .relChan(relChan),
    .grantValid(grantValid), .denyValid(denyValid), .grantChan(grantChan),
    .grantClient(grantClient), .relErr(relErr), .chanBusy(chanBusy), .chanOwner(chanOwner)
  );

  task automatic checkVal(input string tag, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int refPick();
    int nLev = (((NCH - 1) & 15) >> 2) + 1;
    for (int lvl = 0; lvl < nLev; lvl++)
      for (int i = 0; i < NCH; i++)
        if (((i >> 2) & 3) == lvl && !refBusy[i]) return i;
    return -1;
  endfunction

  function automatic int lowestClient(input logic [NCL-1:0] rq);
    for (int c = 0; c < NCL; c++) if (rq[c]) return c;
    return -1;
  endfunction

  task automatic refClear();
    for (int i = 0; i < NCH; i++) begin refBusy[i] = 0; refOwner[i] = 0; end
  endtask

  task automatic compareState(input string tag);
    for (int i = 0; i < NCH; i++) begin
      checkVal({tag, " busy"}, int'(chanBusy[i]), int'(refBusy[i]));
      checkVal({tag, " owner"}, int'(chanOwner[i*CW +: CW]), refOwner[i]);
    end
  endtask

  // drive one cycle of stimulus, predict, sample after the edge
  task automatic step(input logic [NCL-1:0] rq, input bit rv, input int rc, input string tag);
    int cli = lowestClient(rq);
    int pk  = refPick();
    bit relOk = rv && rc < NCH && refBusy[rc];
    bit eG = (cli >= 0) && (pk >= 0);
    bit eD = (cli >= 0) && (pk < 0);
    reqVec = rq; relValid = rv; relChan = 5'(rc);
    @(posedge clk); #1;
    reqVec = '0; relValid = 1'b0; relChan = '0;
    if (relOk) begin refBusy[rc] = 0; refOwner[rc] = 0; end
    if (eG) begin refBusy[pk] = 1; refOwner[pk] = cli; end
    checkVal({tag, " grantValid"}, int'(grantValid), int'(eG));
    checkVal({tag, " denyValid R6"}, int'(denyValid), int'(eD));
    checkVal({tag, " grantChan R10"}, int'(grantChan), eG ? pk : 0);
    checkVal({tag, " grantClient R5"}, int'(grantClient), (cli >= 0) ? cli : 0);
    checkVal({tag, " relErr R8"}, int'(relErr), int'(rv && !relOk));
    compareState({tag, " R4"});
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    refClear();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    doReset();
    // R1 reset state
    checkVal("R1 grantValid", int'(grantValid), 0);
    checkVal("R1 denyValid", int'(denyValid), 0);
    checkVal("R1 relErr", int'(relErr), 0);
    checkVal("R1 busy", int'(chanBusy), 0);
    checkVal("R1 owner", int'(chanOwner != '0), 0);

    // R2 fill order: 0..3 then 16..19 then 4..7 ...
    for (int k = 0; k < NCH; k++) begin
      step(NCL'(1) << (k % NCL), 0, 0, "R2 R3 fill");
      if (k == 4) checkVal("R2 ch16 after 0-3", int'(grantChan), 16);
      if (k == 8) checkVal("R2 ch4 after level0", int'(grantChan), 4);
    end
    // R6 pool full
    step(8'h02, 0, 0, "R6 full");
    checkVal("R6 deny client", int'(grantClient), 1);
    // R7 release then regain
    step('0, 1, 20, "R7 release20");
    step('0, 1, 2, "R7 release2");
    step(8'h08, 0, 0, "R7 regrant");
    checkVal("R7 urgent first", int'(grantChan), 2);
    // R8 double release of a free channel
    step('0, 1, 20, "R8 bad release");
    checkVal("R8 busy20 stays free", int'(chanBusy[20]), 0);
    // R5 simultaneous
    step(8'h14, 0, 0, "R5 simultaneous");
    checkVal("R5 winner", int'(grantClient), 2);
    checkVal("R5 grant ch20", int'(grantChan), 20);
    // R9 release and request in the same cycle with a full pool
    step(8'h01, 1, 9, "R9 same cycle");
    checkVal("R9 denied", int'(denyValid), 1);
    step(8'h01, 0, 0, "R9 after");
    checkVal("R9 regrant 9", int'(grantChan), 9);

    // random phase
    doReset();
    for (int n = 0; n < 4000; n++) begin
      logic [NCL-1:0] rq;
      bit rv;
      int rc;
      rq = (($urandom % 3) == 0) ? NCL'($urandom) : '0;
      rv = (($urandom % 3) == 0);
      rc = int'($urandom % NCH);
      if (rv && ($urandom % 4) != 0) begin
        for (int t = 0; t < NCH; t++)
          if (refBusy[(rc + t) % NCH]) begin rc = (rc + t) % NCH; break; end
      end
      step(rq, rv, rc, "R3 R4 random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule